// File: doc/BRIEF.md
# Selectable-Pin Port Interrupt Generator

This block is the front end for eight external interrupt channels. Each channel watches one of four candidate input pins, chosen by a 2-bit select code. The channel adjusts the chosen signal for polarity, then triggers on an edge or on a level, and latches a per-channel request flag. All candidate pins go through a two-flop synchronizer before selection, so asynchronous pin activity reaches the flags in a known number of cycles.

Software programs the block through a small byte-wide register bus. The bus sets the select codes, the polarity, the trigger mode and the per-channel enables. It also clears flags: a write of 1 to a flag bit clears that flag. The eight flags are visible as outputs. A single combined interrupt output is asserted while any enabled flag is set.

Each channel runs a two-state machine. In `CH_SETTLE`, edge detection is off and the channel only records its current polarity-adjusted input. In `CH_WATCH`, the channel detects edges. Reset enters `CH_SETTLE`. Any write to a field that belongs to the channel (its select code, its polarity, or its mode) moves the channel to `CH_SETTLE` for one cycle. A cycle in `CH_SETTLE` with no such write moves to `CH_WATCH`. `CH_WATCH` stays in `CH_WATCH` until the next such write. This state machine stops a source switch or a polarity change from producing a false edge.

Top module: `pin_irq_gen`

## Requirements
- R1: After reset, the flags and `irq_o` are 0, and every register reads back 0.
- R2: Channel n takes its source from its select code. Code 00 selects `grp0_i[n]`. Code 01 selects `grp1k_i[n]` for n = 0..4 and `grp1p_i[n-4]` for n = 5..7. Code 10 selects `grp2_i[n]`. Code 11 selects `grp3_i[n]`. Pins that are not selected have no effect on the channel.
- R3: A pin change driven between clock edges shows up on the flag after the third rising edge, and not after the second.
- R4: In edge mode (mode bit 0), polarity 1 sets the flag on a rising edge and polarity 0 sets it on a falling edge. The opposite edge has no effect.
- R5: In level mode (mode bit 1), the flag sets on every cycle the active level is present: high for polarity 1, low for polarity 0.
- R6: A write to the flag register clears each flag whose data bit is 1 and leaves the other flags unchanged. In level mode, a flag with its active level still present sets again one cycle later.
- R7: For one cycle after a write to a channel's select code, polarity or mode, that channel does not detect edges. A source switch therefore does not set the flag.
- R8: `irq_o` is the OR over all channels of the flag ANDed with the enable bit.
- R9: The register map is: address 0 holds the select codes for channels 0–3, two bits per channel at bits [1:0], [3:2], [5:4] and [7:6]. Address 1 holds channels 4–7 in the same bit positions. Address 2 is polarity, address 3 is mode, address 4 is enable, and address 5 is the flags (reads return the flags, writes clear them). Bit n of addresses 2–5 belongs to channel n. Addresses 6 and 7 read as 0.
- R10: In edge mode, a flag stays set after its input returns to the inactive state, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| grp0_i | input | 8 | Candidate pins for select code 00 |
| grp1k_i | input | 5 | Candidate pins for select code 01, channels 0–4 |
| grp1p_i | input | 3 | Candidate pins for select code 01, channels 5–7 (indices 3:1) |
| grp2_i | input | 8 | Candidate pins for select code 10 |
| grp3_i | input | 8 | Candidate pins for select code 11 |
| flag_o | output | 8 | Per-channel interrupt request flags |
| irq_o | output | 1 | Combined enabled interrupt |

## Verification
The hardest case to reach from the ports is edge suppression. The channel must be in edge mode, and a pin that is not selected must sit at the active level while the selected pin is idle. The select code is then rewritten so that the channel's input jumps at once. The bench holds `grp3_i[1]` high while channel 1 watches `grp0_i[1]`, then switches the channel to code 11. It checks that no flag appears. It then toggles the pin for real and checks that a genuine edge is still caught.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int NUM_CH  = 8;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 1 << SEL_W;
    localparam int CH_PER_SEL_REG = DATA_W / SEL_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEL_LO = 3'd0,
        REG_SEL_HI = 3'd1,
        REG_POL    = 3'd2,
        REG_MODE   = 3'd3,
        REG_EN     = 3'd4,
        REG_FLAG   = 3'd5,
        REG_RSV6   = 3'd6,
        REG_RSV7   = 3'd7
    } reg_addr_e;

    typedef enum logic {
        CH_SETTLE = 1'b0,
        CH_WATCH  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    wr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [NUM_CH-1:0]       flag_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [NUM_CH*SEL_W-1:0] sel_o,
    output logic [NUM_CH-1:0]       pol_o,
    output logic [NUM_CH-1:0]       level_o,
    output logic [NUM_CH-1:0]       en_o,
    output logic [NUM_CH-1:0]       clr_o,
    output logic [NUM_CH-1:0]       cfg_wr_o
);
    localparam logic [NUM_CH-1:0] LO_MASK = NUM_CH'((1 << CH_PER_SEL_REG) - 1);

    reg_addr_e        addr_e;
    logic [DATA_W-1:0] sel_lo_q, sel_hi_q;
    logic [NUM_CH-1:0] pol_q, mode_q, en_q;

    assign addr_e = reg_addr_e'(addr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            pol_q    <= '0;
            mode_q   <= '0;
            en_q     <= '0;
        end else if (wr_i) begin
            unique case (addr_e)
                REG_SEL_LO: sel_lo_q <= wdata_i;
                REG_SEL_HI: sel_hi_q <= wdata_i;
                REG_POL:    pol_q    <= wdata_i;
                REG_MODE:   mode_q   <= wdata_i;
                REG_EN:     en_q     <= wdata_i;
                default:    ;
            endcase
        end
    end

    always_comb begin
        cfg_wr_o = '0;
        if (wr_i) begin
            unique case (addr_e)
                REG_SEL_LO:        cfg_wr_o = LO_MASK;
                REG_SEL_HI:        cfg_wr_o = ~LO_MASK;
                REG_POL, REG_MODE: cfg_wr_o = '1;
                default:           cfg_wr_o = '0;
            endcase
        end
    end

    assign clr_o = (wr_i && addr_e == REG_FLAG) ? wdata_i : '0;

    always_comb begin
        unique case (addr_e)
            REG_SEL_LO: rdata_o = sel_lo_q;
            REG_SEL_HI: rdata_o = sel_hi_q;
            REG_POL:    rdata_o = pol_q;
            REG_MODE:   rdata_o = mode_q;
            REG_EN:     rdata_o = en_q;
            REG_FLAG:   rdata_o = flag_i;
            default:    rdata_o = '0;
        endcase
    end

    assign sel_o   = {sel_hi_q, sel_lo_q};
    assign pol_o   = pol_q;
    assign level_o = mode_q;
    assign en_o    = en_q;
endmodule

// File: rtl/pirq_chan.sv
module pirq_chan
    import pirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cand_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               pol_i,
    input  logic               level_i,
    input  logic               cfg_wr_i,
    input  logic               clr_i,
    output logic               flag_o
);
    ch_state_e state_q, state_d;
    logic      act;
    logic      prev_q;
    logic      flag_q;
    logic      edge_ok;
    logic      hit;

    assign act = pol_i ? cand_i[sel_i] : ~cand_i[sel_i];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_SETTLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        edge_ok = 1'b0;
        unique case (state_q)
            CH_SETTLE: begin
                edge_ok = 1'b0;
                state_d = cfg_wr_i ? CH_SETTLE : CH_WATCH;
            end
            CH_WATCH: begin
                edge_ok = 1'b1;
                state_d = cfg_wr_i ? CH_SETTLE : CH_WATCH;
            end
            default: begin
                edge_ok = 1'b0;
                state_d = CH_SETTLE;
            end
        endcase
        hit = level_i ? act : (edge_ok && act && !prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= act;
            if (clr_i) flag_q <= 1'b0;
            else       flag_q <= flag_q | hit;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/pin_irq_gen.sv
module pin_irq_gen
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [7:0]        grp0_i,
    input  logic [4:0]        grp1k_i,
    input  logic [3:1]        grp1p_i,
    input  logic [7:0]        grp2_i,
    input  logic [7:0]        grp3_i,
    output logic [NUM_CH-1:0] flag_o,
    output logic              irq_o
);
    localparam int SYNC_W = 8 + 5 + 3 + 8 + 8;

    logic [SYNC_W-1:0]       pins_s;
    logic [7:0]              grp0_s, grp2_s, grp3_s;
    logic [4:0]              grp1k_s;
    logic [3:1]              grp1p_s;
    logic [NUM_CH*SEL_W-1:0] sel;
    logic [NUM_CH-1:0]       pol, level, en, clr, cfg_wr, flags;

    pirq_sync #(.WIDTH(SYNC_W)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({grp3_i, grp2_i, grp1p_i, grp1k_i, grp0_i}),
        .q_o   (pins_s)
    );

    assign grp0_s  = pins_s[7:0];
    assign grp1k_s = pins_s[12:8];
    assign grp1p_s = pins_s[15:13];
    assign grp2_s  = pins_s[23:16];
    assign grp3_s  = pins_s[31:24];

    pirq_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .wr_i     (wr_i),
        .wdata_i  (wdata_i),
        .flag_i   (flags),
        .rdata_o  (rdata_o),
        .sel_o    (sel),
        .pol_o    (pol),
        .level_o  (level),
        .en_o     (en),
        .clr_o    (clr),
        .cfg_wr_o (cfg_wr)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [NUM_SRC-1:0] cand;
        logic               alt;
        if (n < 5) begin : g_key
            assign alt = grp1k_s[n];
        end else begin : g_port
            assign alt = grp1p_s[n-4];
        end
        assign cand = {grp3_s[n], grp2_s[n], alt, grp0_s[n]};

        pirq_chan chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cand_i   (cand),
            .sel_i    (sel[n*SEL_W +: SEL_W]),
            .pol_i    (pol[n]),
            .level_i  (level[n]),
            .cfg_wr_i (cfg_wr[n]),
            .clr_i    (clr[n]),
            .flag_o   (flags[n])
        );
    end

    assign flag_o = flags;
    assign irq_o  = |(flags & en);
endmodule

// File: rtl/pin_irq_gen_chk.sv
module pin_irq_gen_chk
    import pirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [NUM_CH-1:0] flag_o,
    input logic              irq_o
);
    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (flag_o == '0 && !irq_o));

    // R8
    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o != '0));

    // R9
    p_flag_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == REG_FLAG) |-> (rdata_o == flag_o));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
        // R6
        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == REG_FLAG && wdata_i[n]) |=> !flag_o[n]);
        // R10
        p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[n] && !(wr_i && addr_i == REG_FLAG && wdata_i[n])) |=> flag_o[n]);
    end
endmodule

bind pin_irq_gen pin_irq_gen_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .flag_o  (flag_o),
    .irq_o   (irq_o)
);

// File: tb/pin_irq_gen_tb_top.sv
module pin_irq_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] grp0 = '0;
    logic [4:0] grp1k = '0;
    logic [3:1] grp1p = '0;
    logic [7:0] grp2 = '0;
    logic [7:0] grp3 = '0;
    logic [7:0] flag;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rdata), .grp0_i(grp0), .grp1k_i(grp1k), .grp1p_i(grp1p),
        .grp2_i(grp2), .grp3_i(grp3), .flag_o(flag), .irq_o(irq)
    );

    // {channel[2:0], select code[1:0]}
    localparam logic [4:0] VEC [12] = '{
        {3'd0, 2'd0}, {3'd1, 2'd1}, {3'd2, 2'd2}, {3'd3, 2'd3},
        {3'd4, 2'd1}, {3'd5, 2'd1}, {3'd6, 2'd1}, {3'd7, 2'd1},
        {3'd4, 2'd0}, {3'd5, 2'd3}, {3'd6, 2'd2}, {3'd7, 2'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic set_src(input logic [1:0] code, input int ch, input logic v);
        case (code)
            2'd0: grp0[ch] = v;
            2'd1: if (ch < 5) grp1k[ch] = v; else grp1p[ch-4] = v;
            2'd2: grp2[ch] = v;
            default: grp3[ch] = v;
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        check("R1 flags", flag, 0);
        check("R1 irq", irq, 0);
        for (int a = 0; a < 8; a++) rd_chk("R1 readback", 3'(a), 8'h00);

        // R2 table walk: level mode, polarity high
        wr_reg(3'd2, 8'hFF);
        wr_reg(3'd3, 8'hFF);
        wr_reg(3'd5, 8'hFF);
        wait_n(2);
        for (int i = 0; i < 12; i++) begin
            int ch = int'(VEC[i][4:2]);
            logic [1:0] code = VEC[i][1:0];
            logic [7:0] sv = 8'(code) << (2 * (ch % 4));
            wr_reg(3'd0, (ch < 4) ? sv : 8'h00);
            wr_reg(3'd1, (ch < 4) ? 8'h00 : sv);
            wait_n(2);
            set_src(code, ch, 1'b1);
            wait_n(4);
            check("R2 selected pin", flag, 32'(8'h01 << ch));
            set_src(code, ch, 1'b0);
            for (int c = 0; c < 4; c++) if (c != int'(code)) set_src(2'(c), ch, 1'b1);
            wait_n(4);
            wr_reg(3'd5, 8'hFF);
            wait_n(4);
            check("R2 unselected pins ignored", flag, 0);
            for (int c = 0; c < 4; c++) set_src(2'(c), ch, 1'b0);
            wait_n(4);
        end

        // R3/R4/R10 edge mode on channel 0, code 10
        wr_reg(3'd3, 8'h00);
        wr_reg(3'd2, 8'h01);
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd0, 8'h02);
        wr_reg(3'd5, 8'hFF);
        wait_n(3);
        grp2[0] = 1'b1;
        wait_n(2);
        check("R3 not after second edge", flag, 0);
        wait_n(1);
        check("R3 after third edge / R4 rising", flag, 8'h01);
        grp2[0] = 1'b0;
        wait_n(4);
        check("R10 flag held", flag, 8'h01);
        wr_reg(3'd5, 8'h01);
        wait_n(4);
        check("R4 falling ignored with pol 1", flag, 0);
        wr_reg(3'd2, 8'h00);
        wait_n(3);
        grp2[0] = 1'b1;
        wait_n(4);
        check("R4 rising ignored with pol 0", flag, 0);
        grp2[0] = 1'b0;
        wait_n(4);
        check("R4 falling with pol 0", flag, 8'h01);
        wr_reg(3'd5, 8'hFF);

        // R7 source switch on channel 1
        wr_reg(3'd2, 8'h02);
        wr_reg(3'd0, 8'h00);
        wait_n(3);
        grp3[1] = 1'b1;
        wait_n(4);
        check("R7 idle before switch", flag, 0);
        wr_reg(3'd0, 8'h0C);
        wait_n(4);
        check("R7 no flag on source switch", flag, 0);
        grp3[1] = 1'b0;
        wait_n(4);
        grp3[1] = 1'b1;
        wait_n(4);
        check("R7 real edge after settle", flag, 8'h02);
        grp3[1] = 1'b0;
        wr_reg(3'd5, 8'hFF);

        // R5/R6/R8 level on ch2, edge on ch3, both code 10
        wr_reg(3'd3, 8'h04);
        wr_reg(3'd2, 8'h0C);
        wr_reg(3'd0, 8'hA0);
        wait_n(3);
        grp2[3:2] = 2'b11;
        wait_n(4);
        check("R5 level high and edge", flag, 8'h0C);
        wr_reg(3'd5, 8'h04);
        check("R6 selective clear", flag, 8'h08);
        wait_n(1);
        check("R6 level re-sets", flag, 8'h0C);
        wr_reg(3'd4, 8'h00);
        check("R8 no enable", irq, 0);
        wr_reg(3'd4, 8'h08);
        check("R8 enabled flag", irq, 1);
        wr_reg(3'd4, 8'h20);
        check("R8 enable without flag", irq, 0);
        grp2[3:2] = 2'b00;
        wait_n(4);
        wr_reg(3'd5, 8'h0C);
        check("R6 clear both", flag, 0);
        wr_reg(3'd2, 8'h08);
        wait_n(2);
        check("R5 low level with pol 0", flag, 8'h04);

        // R9 readback
        wr_reg(3'd1, 8'hE4);
        wr_reg(3'd7, 8'h5A);
        rd_chk("R9 select high", 3'd1, 8'hE4);
        rd_chk("R9 select low", 3'd0, 8'hA0);
        rd_chk("R9 enable", 3'd4, 8'h20);
        rd_chk("R9 mode", 3'd3, 8'h04);
        rd_chk("R9 flags", 3'd5, flag);
        rd_chk("R9 reserved", 3'd7, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule